// File: doc/BRIEF.md
# Eight-Bit ALU With Status Flag Generation

This block is the arithmetic and logic stage of a small 8-bit processor core. On each accepted operation it takes two operands and the current contents of the status register from outside, computes a result, and returns the status register with the flags that operation touches rewritten. Every operation has its own mask of flags that it rewrites. A flag outside the mask is copied from the incoming status value, so one status register owned elsewhere can be written back every time. The interrupt-enable and bit-copy bits always pass through untouched.

The supported operations are add, subtract, compare, compare against an immediate, bitwise AND, increment, logical shift left, an unsigned multiply with a double-width product, and two copy operations (register move and immediate load) that change no flag. Single-cycle operations complete one clock after they are issued. The multiply has its own two-stage path and completes two clocks after issue. Register file access, writeback selection and interrupt handling are left to the surrounding core.

Top module: `alu_flag_unit`

## Requirements
- R1: While reset is held low at a clock edge, `result`, `product` and `status_out` are all zero and `done` is low.
- R2: The status layout, bit 7 down to bit 0, is I, T, H, S, V, N, Z, C; no operation changes bits 7 (I) and 6 (T), which are copied from `status_in`.
- R3: Code 0 (add) gives `result` = opa + opb modulo 256; C is the carry out of bit 7, H is the carry from bit 3 into bit 4, V is set when both operands share a sign that the result does not have, N is result bit 7, Z is set for a zero result, and S = N xor V.
- R4: Code 1 (subtract) gives `result` = opa - opb modulo 256; C is set when opa < opb unsigned, H is set when the low nibble of opa is below that of opb, V is set when the operand signs differ and the result sign differs from opa, and N, Z and S follow the difference as in R3.
- R5: Codes 2 (compare) and 3 (compare immediate, with the immediate on `opb`) set H, S, V, N, Z and C exactly as code 1 does, and return `result` = opa unchanged.
- R6: Code 4 (AND) gives `result` = opa & opb, clears V, sets N, Z and S from the result, and keeps H and C from `status_in`.
- R7: Code 5 (increment) gives `result` = opa + 1 modulo 256, sets V only when opa is 0x7F, sets N, Z and S from the result, and keeps H and C from `status_in`.
- R8: Code 6 (shift left) gives `result` = opa shifted left by one with a zero in bit 0; C takes opa bit 7, H takes opa bit 3, V = N xor C, and N, Z and S follow the result.
- R9: Code 7 (multiply) puts the unsigned 16-bit product of opa and opb on `product` and its low byte on `result`, sets C from product bit 15 and Z when the product is zero, keeps H, S, V and N from the `status_in` value present at issue, and raises `done` two clocks after issue with `done` low after the first.
- R10: An `op_valid` in the clock right after a multiply is issued is dropped: it produces no `done` and no change to any output.
- R11: Codes 8 (move) and 9 (load immediate) give `result` = opb and return `status_out` equal to `status_in`.
- R12: For codes 0 to 6, 8 and 9, `done` pulses high one clock after issue and `product` keeps its previous value; codes 10 to 15 are ignored, producing no `done` and leaving every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Issue strobe for the operation on the other inputs |
| op_code | input | 4 | Operation select, codes 0 to 9 |
| opa | input | 8 | First operand (destination value) |
| opb | input | 8 | Second operand or immediate |
| status_in | input | 8 | Current status register contents |
| result | output | 8 | Result byte of the last completed operation |
| product | output | 16 | Product of the last completed multiply |
| status_out | output | 8 | Updated status register of the last completed operation |
| done | output | 1 | One-clock pulse when an operation completes |

## Verification
Every single-cycle result, with its flags, is due after the first rising edge following issue. The bench drives inputs on the falling edge and samples on the next falling edge, half a period after the one register stage. A multiply is due after the second rising edge. The bench first confirms that `done` is still low one falling edge after issue, then checks product, result and flags one falling edge later. For the dropped-operation and illegal-code cases, the bench looks both at the completion slot and at the falling edge after it, to show that no second pulse and no output change arrive late.

// File: rtl/alu_flag_pkg.sv
// Package: shared opcode encoding, status bit positions and the per-operation
// flag update masks used by the ALU and its sub-blocks.
// Assumes an 8-bit status register; the opcode field is 4 bits wide.
package alu_flag_pkg;

    localparam int SR_W  = 8;
    localparam int OPC_W = 4;

    // Status bit positions (the surrounding core decodes these).
    localparam int F_C = 0;
    localparam int F_Z = 1;
    localparam int F_N = 2;
    localparam int F_V = 3;
    localparam int F_S = 4;
    localparam int F_H = 5;
    localparam int F_T = 6;
    localparam int F_I = 7;

    typedef enum logic [OPC_W-1:0] {
        OPC_ADD  = 4'd0,
        OPC_SUB  = 4'd1,
        OPC_CMP  = 4'd2,
        OPC_CMPI = 4'd3,
        OPC_AND  = 4'd4,
        OPC_INC  = 4'd5,
        OPC_LSL  = 4'd6,
        OPC_MUL  = 4'd7,
        OPC_MOV  = 4'd8,
        OPC_LDI  = 4'd9
    } opc_e;

    // Flags rewritten by each operation; bits outside the mask are held.
    function automatic logic [SR_W-1:0] upd_mask(input logic [OPC_W-1:0] opc);
        logic [SR_W-1:0] m;
        m = '0;
        case (opc)
            OPC_ADD, OPC_SUB, OPC_CMP, OPC_CMPI, OPC_LSL: begin
                m[F_H] = 1'b1; m[F_S] = 1'b1; m[F_V] = 1'b1;
                m[F_N] = 1'b1; m[F_Z] = 1'b1; m[F_C] = 1'b1;
            end
            OPC_AND, OPC_INC: begin
                m[F_S] = 1'b1; m[F_V] = 1'b1; m[F_N] = 1'b1; m[F_Z] = 1'b1;
            end
            OPC_MUL: begin
                m[F_Z] = 1'b1; m[F_C] = 1'b1;
            end
            default: m = '0;
        endcase
        return m;
    endfunction

    // True for every defined operation code.
    function automatic logic opc_legal(input logic [OPC_W-1:0] opc);
        return (opc <= OPC_LDI);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
// Adder/subtractor with carry, half-carry and overflow outputs.
// For subtraction the carry and half-carry are reported as borrows
// (set when the minuend is the smaller value). Purely combinational.
// Assumes DATA_W is even so the half-carry sits at the nibble boundary.
module alu_addsub #(
    parameter int DATA_W = 8
) (
    input  logic              sub_en,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum,
    output logic              c_out,
    output logic              h_out,
    output logic              v_out
);
    localparam int HALF = DATA_W / 2;
    localparam int MSB  = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   full;
    logic [HALF:0]     low;

    // Two's-complement add of a and (possibly inverted) b, plus nibble carry.
    always_comb begin
        b_eff = sub_en ? ~b : b;
        full  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_en};
        low   = {1'b0, a[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + {{HALF{1'b0}}, sub_en};
        sum   = full[DATA_W-1:0];
        c_out = full[DATA_W] ^ sub_en;
        h_out = low[HALF] ^ sub_en;
        v_out = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end

endmodule

// File: rtl/alu_unary.sv
// AND, increment and shift-left datapath with their carry, half-carry and
// overflow terms. Purely combinational; outputs for other codes are zero.
// Assumes DATA_W >= 4 and even.
module alu_unary
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [OPC_W-1:0]  opc,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] r,
    output logic              c_out,
    output logic              h_out,
    output logic              v_out
);
    localparam int HALF = DATA_W / 2;
    localparam int MSB  = DATA_W - 1;
    localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};

    // Select the operation and derive its carry-type terms.
    always_comb begin
        r     = '0;
        c_out = 1'b0;
        h_out = 1'b0;
        v_out = 1'b0;
        case (opc)
            OPC_AND: begin
                r = a & b;
            end
            OPC_INC: begin
                r     = a + {{(DATA_W-1){1'b0}}, 1'b1};
                v_out = (a == MAX_POS);
            end
            OPC_LSL: begin
                r     = {a[DATA_W-2:0], 1'b0};
                c_out = a[MSB];
                h_out = a[HALF-1];
                v_out = a[MSB] ^ a[DATA_W-2];
            end
            default: begin
                r = '0;
            end
        endcase
    end

endmodule

// File: rtl/alu_mul.sv
// Two-stage unsigned multiplier. Stage one captures the operands on start;
// stage two registers the product. busy is high during the cycle in which
// the product is being formed; prod_now is the product of the held operands.
// Assumes start is never raised while busy is high (the top drops it).
module alu_mul #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    output logic                busy,
    output logic [2*DATA_W-1:0] prod_now,
    output logic [2*DATA_W-1:0] prod_q
);
    localparam int PROD_W = 2 * DATA_W;

    logic [DATA_W-1:0] a_q;
    logic [DATA_W-1:0] b_q;
    logic              busy_q;

    // Stage one: hold the operands for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            busy_q <= 1'b0;
        end else begin
            busy_q <= start;
            if (start) begin
                a_q <= a;
                b_q <= b;
            end
        end
    end

    // Product of the held operands.
    always_comb begin
        prod_now = PROD_W'(a_q) * PROD_W'(b_q);
    end

    // Stage two: register the product; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
        end else if (busy_q) begin
            prod_q <= prod_now;
        end
    end

    assign busy = busy_q;

    // R10: the multiplier is busy for exactly one cycle per issue.
    assert_busy_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> !busy_q);

endmodule

// File: rtl/alu_flag_merge.sv
// Merges freshly computed flags into the old status value under a mask:
// masked bits take the new value, the rest keep the old one. Combinational.
module alu_flag_merge
    import alu_flag_pkg::*;
(
    input  logic [SR_W-1:0] old_sr,
    input  logic [SR_W-1:0] calc_sr,
    input  logic [SR_W-1:0] mask,
    output logic [SR_W-1:0] new_sr
);
    // Per-bit select between held and computed flag.
    always_comb begin
        new_sr = (old_sr & ~mask) | (calc_sr & mask);
    end

endmodule

// File: rtl/alu_flag_unit.sv
// Top of the ALU: decodes the operation, runs the single-cycle datapaths and
// the two-stage multiplier, builds the flags, merges them into the incoming
// status value and registers result, status and a completion pulse.
// Assumes the caller presents status_in with the operation and owns the
// status register; an issue in the cycle after a multiply issue is dropped.
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [OPC_W-1:0]    op_code,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    input  logic [SR_W-1:0]     status_in,
    output logic [DATA_W-1:0]   result,
    output logic [2*DATA_W-1:0] product,
    output logic [SR_W-1:0]     status_out,
    output logic                done
);
    localparam int MSB    = DATA_W - 1;
    localparam int PROD_W = 2 * DATA_W;

    logic              mul_pend;
    logic              accept;
    logic              go_single;
    logic              go_mul;
    logic [DATA_W-1:0] as_sum;
    logic              as_c, as_h, as_v;
    logic [DATA_W-1:0] un_r;
    logic              un_c, un_h, un_v;
    logic [DATA_W-1:0] flag_val;
    logic [DATA_W-1:0] out_val;
    logic              c_sel, h_sel, v_sel;
    logic [SR_W-1:0]   calc_single;
    logic [SR_W-1:0]   sr_single;
    logic [PROD_W-1:0] prod_now;
    logic [SR_W-1:0]   sin_mul_q;
    logic [SR_W-1:0]   calc_mul;
    logic [SR_W-1:0]   sr_mul;
    logic [DATA_W-1:0] res_q;
    logic [SR_W-1:0]   sreg_q;
    logic              done_q;
    logic [OPC_W-1:0]  op_q;

    // Issue qualification: drop issues while the multiplier is forming a product.
    always_comb begin
        accept    = op_valid && !mul_pend;
        go_mul    = accept && (op_code == OPC_MUL);
        go_single = accept && opc_legal(op_code) && (op_code != OPC_MUL);
    end

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .sub_en (op_code != OPC_ADD),
        .a      (opa),
        .b      (opb),
        .sum    (as_sum),
        .c_out  (as_c),
        .h_out  (as_h),
        .v_out  (as_v)
    );

    alu_unary #(.DATA_W(DATA_W)) u_unary (
        .opc    (op_code),
        .a      (opa),
        .b      (opb),
        .r      (un_r),
        .c_out  (un_c),
        .h_out  (un_h),
        .v_out  (un_v)
    );

    // Pick the value the flags describe and the value returned as result.
    always_comb begin
        flag_val = opa;
        out_val  = opa;
        c_sel    = 1'b0;
        h_sel    = 1'b0;
        v_sel    = 1'b0;
        case (op_code)
            OPC_ADD, OPC_SUB: begin
                flag_val = as_sum; out_val = as_sum;
                c_sel = as_c; h_sel = as_h; v_sel = as_v;
            end
            OPC_CMP, OPC_CMPI: begin
                flag_val = as_sum; out_val = opa;
                c_sel = as_c; h_sel = as_h; v_sel = as_v;
            end
            OPC_AND, OPC_INC, OPC_LSL: begin
                flag_val = un_r; out_val = un_r;
                c_sel = un_c; h_sel = un_h; v_sel = un_v;
            end
            OPC_MOV, OPC_LDI: begin
                flag_val = opb; out_val = opb;
            end
            default: begin
                flag_val = opa; out_val = opa;
            end
        endcase
    end

    // Candidate flags of a single-cycle operation (I and T never produced).
    always_comb begin
        calc_single        = '0;
        calc_single[F_C]   = c_sel;
        calc_single[F_Z]   = (flag_val == '0);
        calc_single[F_N]   = flag_val[MSB];
        calc_single[F_V]   = v_sel;
        calc_single[F_S]   = flag_val[MSB] ^ v_sel;
        calc_single[F_H]   = h_sel;
    end

    alu_flag_merge u_merge_single (
        .old_sr  (status_in),
        .calc_sr (calc_single),
        .mask    (upd_mask(op_code)),
        .new_sr  (sr_single)
    );

    alu_mul #(.DATA_W(DATA_W)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (go_mul),
        .a        (opa),
        .b        (opb),
        .busy     (mul_pend),
        .prod_now (prod_now),
        .prod_q   (product)
    );

    // Keep the status value seen at multiply issue for the completion cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sin_mul_q <= '0;
        end else if (go_mul) begin
            sin_mul_q <= status_in;
        end
    end

    // Candidate flags of the multiply: carry from the product top bit, zero test.
    always_comb begin
        calc_mul      = '0;
        calc_mul[F_C] = prod_now[PROD_W-1];
        calc_mul[F_Z] = (prod_now == '0);
    end

    alu_flag_merge u_merge_mul (
        .old_sr  (sin_mul_q),
        .calc_sr (calc_mul),
        .mask    (upd_mask(OPC_MUL)),
        .new_sr  (sr_mul)
    );

    // Output registers: load on single-cycle issue or multiply completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            sreg_q <= '0;
            done_q <= 1'b0;
            op_q   <= '0;
        end else begin
            done_q <= go_single || mul_pend;
            if (go_single) begin
                res_q  <= out_val;
                sreg_q <= sr_single;
                op_q   <= op_code;
            end else if (mul_pend) begin
                res_q  <= prod_now[DATA_W-1:0];
                sreg_q <= sr_mul;
                op_q   <= OPC_MUL;
            end
        end
    end

    assign result     = res_q;
    assign status_out = sreg_q;
    assign done       = done_q;

    // R2: I and T come back exactly as presented.
    assert_it_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        go_single |=> status_out[F_I:F_T] == $past(status_in[F_I:F_T]));

    // R3: for result-producing flag operations, N, Z and S agree with the result.
    assert_result_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && (op_q == OPC_ADD || op_q == OPC_SUB || op_q == OPC_AND ||
                    op_q == OPC_INC || op_q == OPC_LSL))
        |-> (status_out[F_Z] == (result == '0)) && (status_out[F_N] == result[MSB]) &&
            (status_out[F_S] == (status_out[F_N] ^ status_out[F_V])));

    // R9: multiply is not done after one cycle, and is done after two.
    assert_mul_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        go_mul |=> (!done_q && mul_pend));

    assert_mul_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mul_pend |=> (done_q && op_q == OPC_MUL));

    // R9: multiply flags track the registered product.
    assert_mul_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && op_q == OPC_MUL) |->
            (status_out[F_C] == product[PROD_W-1]) && (status_out[F_Z] == (product == '0)));

    // R12: single-cycle issue completes next cycle without touching the product.
    assert_single_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        go_single |=> (done_q && $stable(product)));

    // R12: undefined codes never complete.
    assert_illegal_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !mul_pend && !opc_legal(op_code)) |=> !done_q);

endmodule

// File: tb/alu_flag_unit_test.sv
// Directed bench for alu_flag_unit: one task per scenario, each checking its
// own results against a reference model written from the requirements.
module alu_flag_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        op_valid;
    logic [3:0]  op_code;
    logic [7:0]  opa;
    logic [7:0]  opb;
    logic [7:0]  status_in;
    logic [7:0]  result;
    logic [15:0] product;
    logic [7:0]  status_out;
    logic        done;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] exp_prod;

    alu_flag_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .opa        (opa),
        .opb        (opb),
        .status_in  (status_in),
        .result     (result),
        .product    (product),
        .status_out (status_out),
        .done       (done)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Reference: returns {result, status} for single-cycle codes.
    function automatic logic [15:0] model(input logic [3:0] c, input logic [7:0] a,
                                          input logic [7:0] b, input logic [7:0] s);
        logic [7:0] val;
        logic [7:0] out;
        logic [7:0] f;
        logic [8:0] w;
        f   = s;
        val = a;
        out = a;
        if (c == 4'd8 || c == 4'd9) return {b, s};
        case (c)
            4'd0: begin
                w = {1'b0, a} + {1'b0, b};
                val = w[7:0]; out = val;
                f[0] = w[8];
                f[5] = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
                f[3] = (a[7] == b[7]) && (val[7] != a[7]);
            end
            4'd1, 4'd2, 4'd3: begin
                val = a - b;
                out = (c == 4'd1) ? val : a;
                f[0] = a < b;
                f[5] = a[3:0] < b[3:0];
                f[3] = (a[7] != b[7]) && (val[7] != a[7]);
            end
            4'd4: begin
                val = a & b; out = val; f[3] = 1'b0;
            end
            4'd5: begin
                val = a + 8'd1; out = val; f[3] = (a == 8'h7F);
            end
            default: begin
                val = {a[6:0], 1'b0}; out = val;
                f[0] = a[7]; f[5] = a[3]; f[3] = val[7] ^ a[7];
            end
        endcase
        f[2] = val[7];
        f[1] = (val == 8'h00);
        f[4] = f[2] ^ f[3];
        return {out, f};
    endfunction

    task automatic drive(input logic [3:0] c, input logic [7:0] a, input logic [7:0] b, input logic [7:0] s);
        op_valid  = 1'b1;
        op_code   = c;
        opa       = a;
        opb       = b;
        status_in = s;
    endtask

    // Issue one single-cycle operation and check it one clock later.
    task automatic run_single(input string tag, input logic [3:0] c, input logic [7:0] a,
                              input logic [7:0] b, input logic [7:0] s);
        logic [15:0] e;
        e = model(c, a, b, s);
        @(negedge clk);
        drive(c, a, b, s);
        @(negedge clk);
        op_valid = 1'b0;
        chk(tag, "done", {15'd0, done}, 16'd1);
        chk(tag, "result", {8'd0, result}, {8'd0, e[15:8]});
        chk(tag, "status", {8'd0, status_out}, {8'd0, e[7:0]});
        chk("R12", "product held", product, exp_prod);
    endtask

    // Issue one multiply and check both the gap cycle and the completion.
    task automatic run_mul(input logic [7:0] a, input logic [7:0] b, input logic [7:0] s);
        logic [15:0] p;
        logic [7:0]  f;
        p = {8'd0, a} * {8'd0, b};
        f = s;
        f[0] = p[15];
        f[1] = (p == 16'd0);
        @(negedge clk);
        drive(4'd7, a, b, s);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R9", "done low after one clock", {15'd0, done}, 16'd0);
        @(negedge clk);
        chk("R9", "done", {15'd0, done}, 16'd1);
        chk("R9", "product", product, p);
        chk("R9", "result", {8'd0, result}, {8'd0, p[7:0]});
        chk("R9", "status", {8'd0, status_out}, {8'd0, f});
        exp_prod = p;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "result", {8'd0, result}, 16'd0);
        chk("R1", "product", product, 16'd0);
        chk("R1", "status", {8'd0, status_out}, 16'd0);
        chk("R1", "done", {15'd0, done}, 16'd0);
    endtask

    task automatic t_add();
        run_single("R3", 4'd0, 8'h7F, 8'h01, 8'hC0);
        run_single("R3", 4'd0, 8'hFF, 8'h01, 8'h00);
        run_single("R3", 4'd0, 8'h08, 8'h08, 8'h40);
        run_single("R3", 4'd0, 8'h80, 8'h80, 8'h80);
        run_single("R3", 4'd0, 8'h12, 8'h34, 8'h3F);
    endtask

    task automatic t_sub();
        run_single("R4", 4'd1, 8'h10, 8'h01, 8'h00);
        run_single("R4", 4'd1, 8'h00, 8'h01, 8'hC0);
        run_single("R4", 4'd1, 8'h80, 8'h01, 8'h00);
        run_single("R4", 4'd1, 8'h55, 8'h55, 8'h3F);
    endtask

    task automatic t_cmp();
        run_single("R5", 4'd2, 8'h05, 8'h07, 8'h00);
        run_single("R5", 4'd3, 8'h90, 8'h10, 8'h80);
        run_single("R5", 4'd2, 8'h7F, 8'h80, 8'h40);
    endtask

    task automatic t_and();
        run_single("R6", 4'd4, 8'hF0, 8'h0F, 8'h3F);
        run_single("R6", 4'd4, 8'hC3, 8'h81, 8'h00);
    endtask

    task automatic t_inc();
        run_single("R7", 4'd5, 8'h7F, 8'h00, 8'h21);
        run_single("R7", 4'd5, 8'hFF, 8'h00, 8'h21);
        run_single("R7", 4'd5, 8'h00, 8'h00, 8'h08);
    endtask

    task automatic t_lsl();
        run_single("R8", 4'd6, 8'h88, 8'h00, 8'h00);
        run_single("R8", 4'd6, 8'h40, 8'h00, 8'h00);
        run_single("R8", 4'd6, 8'h00, 8'h00, 8'h3F);
        run_single("R8", 4'd6, 8'hC8, 8'h00, 8'h80);
    endtask

    task automatic t_mul();
        run_mul(8'hFF, 8'hFF, 8'hFF);
        run_mul(8'h00, 8'h12, 8'h00);
        run_mul(8'h10, 8'h10, 8'h3C);
    endtask

    task automatic t_copy();
        run_single("R11", 4'd8, 8'h11, 8'h9A, 8'hA5);
        run_single("R11", 4'd9, 8'hEE, 8'h00, 8'h5A);
        run_single("R2", 4'd0, 8'h01, 8'h01, 8'hC0);
    endtask

    // R10: an issue in the cycle after a multiply issue is dropped.
    task automatic t_hazard();
        logic [15:0] p;
        p = 16'h0023 * 16'h0007;
        @(negedge clk);
        drive(4'd7, 8'h23, 8'h07, 8'h00);
        @(negedge clk);
        drive(4'd0, 8'h01, 8'h01, 8'h00);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R10", "multiply done", {15'd0, done}, 16'd1);
        chk("R10", "result from multiply", {8'd0, result}, {8'd0, p[7:0]});
        @(negedge clk);
        chk("R10", "no done for dropped add", {15'd0, done}, 16'd0);
        chk("R10", "result unchanged", {8'd0, result}, {8'd0, p[7:0]});
        chk("R10", "status unchanged", {8'd0, status_out}, 16'd0);
        exp_prod = p;
    endtask

    // R12: undefined codes are ignored.
    task automatic t_illegal();
        logic [7:0] r0;
        logic [7:0] s0;
        run_single("R12", 4'd0, 8'h21, 8'h21, 8'h00);
        r0 = result;
        s0 = status_out;
        @(negedge clk);
        drive(4'd12, 8'hFF, 8'hFF, 8'hFF);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R12", "no done for code 12", {15'd0, done}, 16'd0);
        chk("R12", "result held", {8'd0, result}, {8'd0, r0});
        chk("R12", "status held", {8'd0, status_out}, {8'd0, s0});
        chk("R12", "product held", product, exp_prod);
        @(negedge clk);
        chk("R12", "still no done", {15'd0, done}, 16'd0);
    endtask

    initial begin
        rst_n     = 1'b0;
        op_valid  = 1'b0;
        op_code   = 4'd0;
        opa       = 8'd0;
        opb       = 8'd0;
        status_in = 8'd0;
        exp_prod  = 16'd0;
        repeat (3) @(posedge clk);
        t_reset();
        rst_n = 1'b1;
        t_add();
        t_sub();
        t_cmp();
        t_and();
        t_inc();
        t_lsl();
        t_mul();
        t_copy();
        t_hazard();
        t_illegal();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule